// File: doc/BRIEF.md
# Per-Channel Drive Current On-Time Logger

This block keeps one 8-bit time-step register for each of four driver channels. On every cycle that carries a time-base strobe, a channel's register advances by one if that channel's high-side driver is switched on and its current comparator reports a level above threshold. A register stops at 255 rather than rolling over, so software reading it sees how long the drive current stayed high during a firing event.

A serial front end, outside this block, delivers each completed command byte with a one-cycle valid strobe. The block decodes three command kinds from it. A clear command zeroes any chosen subset of registers. A status request asks for the live comparator vector. A readback request asks for one channel's register. Requests are answered one frame late. The value is captured into the reply register on the strobe of the next valid frame, whatever that frame carries, and it then stays there until the following frame.

Top module: `ontime_logger`

## Requirements
- R1: After synchronous reset, every channel register and the reply register read 0x00.
- R2: On a cycle with the tick strobe high, a channel whose high-side active flag and comparator output are both 1 has its register increased by exactly one.
- R3: A channel register holds its value on any cycle without a tick, or when that channel's driver flag is 0, or when its comparator output is 0.
- R4: A register at 255 stays at 255 on further qualified ticks and does not wrap.
- R5: A frame whose byte has upper nibble 0x3 clears to 0x00 every channel whose bit in the lower nibble is 1 (bit i selects channel i). Channels whose bit is 0 are unchanged.
- R6: When a clear and a qualified tick hit the same channel in the same cycle, the register ends at 0x00.
- R7: After a frame with byte 0x79, the next valid frame loads the reply with the comparator vector sampled on that next frame's strobe cycle. Bit i is channel i and the upper bits are 0.
- R8: After a frame with byte 0x70 plus n (n below the channel count), the next valid frame loads the reply with channel n's register value as it stood just before that frame's clock edge.
- R9: A frame that follows a frame carrying no request loads the reply with 0x00. The reply holds its value on cycles without a valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Time-step strobe |
| hs_act_i | input | NUM_CH | Per-channel high-side driver active flags |
| cmp_hi_i | input | NUM_CH | Per-channel current-above-threshold comparator outputs |
| frame_vld_i | input | 1 | One-cycle strobe marking a valid command frame |
| frame_cmd_i | input | 8 | Command byte of the frame |
| cnt_o | output | NUM_CH*CNT_W | Channel registers, channel i in bits [i*CNT_W +: CNT_W] |
| reply_o | output | CNT_W | Reply register, loaded on each valid frame |

## Verification
Two functions can land on the same cycle: a mask clear of a channel and a qualified tick that would advance that same channel. The bench drives a 0x3 clear frame with the tick, driver flags and comparator all high on every channel. The cleared channels must read zero and the unmasked ones must advance by one. A readback capture can also coincide with a clear of the channel being read, so the bench sends a clear frame right after a readback request. The reply must show the value from before the clear.

// File: rtl/ontime_pkg.sv
package ontime_pkg;
  localparam int CMD_W = 8;
  localparam logic [3:0] GRP_CLEAR = 4'h3;
  localparam logic [3:0] GRP_READ = 4'h7;
  localparam logic [CMD_W-1:0] CODE_STATUS = 8'h79;

  typedef enum logic [1:0] {
    REQ_NONE   = 2'd0,
    REQ_STATUS = 2'd1,
    REQ_READ   = 2'd2
  } req_kind_e;
endpackage

// File: rtl/ontime_cmd_decode.sv
module ontime_cmd_decode
  import ontime_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W = $clog2(NUM_CH)
) (
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              vld_i,
  output logic [NUM_CH-1:0] clr_o,
  output req_kind_e         req_o,
  output logic [CH_W-1:0]   req_ch_o
);
  logic is_clear;
  logic is_read;

  assign is_clear = (cmd_i[7:4] == GRP_CLEAR);
  assign is_read  = (cmd_i[7:4] == GRP_READ) && (int'(cmd_i[3:0]) < NUM_CH);

  // clear mask: lower nibble bit i picks channel i
  always_comb begin
    clr_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      clr_o[i] = vld_i && is_clear && cmd_i[i];
    end
  end

  always_comb begin
    if (cmd_i == CODE_STATUS) req_o = REQ_STATUS;
    else if (is_read)         req_o = REQ_READ;
    else                      req_o = REQ_NONE;
  end

  assign req_ch_o = cmd_i[CH_W-1:0];
endmodule

// File: rtl/ontime_chan_cnt.sv
module ontime_chan_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             act_i,
  input  logic             above_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step = tick_i && act_i && above_i && (cnt_q != CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(tick_i && act_i && above_i)) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/ontime_reply.sv
module ontime_reply
  import ontime_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 8,
  parameter int CH_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    frame_vld_i,
  input  req_kind_e               req_i,
  input  logic [CH_W-1:0]         req_ch_i,
  input  logic [NUM_CH-1:0]       cmp_hi_i,
  input  logic [NUM_CH*CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0]        reply_o
);
  req_kind_e        pend_q;
  logic [CH_W-1:0]  pend_ch_q;
  logic [CNT_W-1:0] reply_q;
  logic [CNT_W-1:0] reply_d;

  always_comb begin
    case (pend_q)
      REQ_STATUS: reply_d = CNT_W'(cmp_hi_i);
      REQ_READ:   reply_d = cnt_i[pend_ch_q*CNT_W +: CNT_W];
      default:    reply_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= REQ_NONE;
      pend_ch_q <= '0;
      reply_q   <= '0;
    end else if (frame_vld_i) begin
      reply_q   <= reply_d;
      pend_q    <= req_i;
      pend_ch_q <= req_ch_i;
    end
  end

  assign reply_o = reply_q;

  AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !frame_vld_i |=> $stable(reply_q)); // R9
  AST_EMPTY_REPLY: assert property (@(posedge clk) disable iff (rst)
    (frame_vld_i && pend_q == REQ_NONE) |=> (reply_q == '0)); // R9
endmodule

// File: rtl/ontime_logger.sv
module ontime_logger
  import ontime_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tick_i,
  input  logic [NUM_CH-1:0]       hs_act_i,
  input  logic [NUM_CH-1:0]       cmp_hi_i,
  input  logic                    frame_vld_i,
  input  logic [CMD_W-1:0]        frame_cmd_i,
  output logic [NUM_CH*CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0]        reply_o
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [NUM_CH-1:0] clr;
  req_kind_e         req;
  logic [CH_W-1:0]   req_ch;

  ontime_cmd_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_dec (
    .cmd_i    (frame_cmd_i),
    .vld_i    (frame_vld_i),
    .clr_o    (clr),
    .req_o    (req),
    .req_ch_o (req_ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ontime_chan_cnt #(.CNT_W(CNT_W)) i_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tick_i),
      .act_i   (hs_act_i[g]),
      .above_i (cmp_hi_i[g]),
      .clr_i   (clr[g]),
      .cnt_o   (cnt_o[g*CNT_W +: CNT_W])
    );
  end

  ontime_reply #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CH_W(CH_W)) i_reply (
    .clk         (clk),
    .rst         (rst),
    .frame_vld_i (frame_vld_i),
    .req_i       (req),
    .req_ch_i    (req_ch),
    .cmp_hi_i    (cmp_hi_i),
    .cnt_i       (cnt_o),
    .reply_o     (reply_o)
  );

  AST_CLR_MASK: assert property (@(posedge clk) disable iff (rst)
    (frame_vld_i && frame_cmd_i[7:4] == GRP_CLEAR && frame_cmd_i[0]) |=> (cnt_o[CNT_W-1:0] == '0)); // R5
endmodule

// File: tb/test_ontime_logger.sv
module test_ontime_logger;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [3:0]  act = '0;
  logic [3:0]  hi = '0;
  logic        fv = 1'b0;
  logic [7:0]  cmd = '0;
  logic [31:0] cnt;
  logic [7:0]  reply;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int exp_cnt [4];
  int pend_kind = 0;   // 0 none, 1 status, 2 readback
  int pend_ch = 0;
  int last_reply = 0;
  bit frame_seen = 1'b0;
  int    exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  ontime_logger i_ontime_logger (
    .clk(clk), .rst(rst), .tick_i(tick), .hs_act_i(act), .cmp_hi_i(hi),
    .frame_vld_i(fv), .frame_cmd_i(cmd), .cnt_o(cnt), .reply_o(reply)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // monitor: pops expected replies once a frame has been clocked
  always @(negedge clk) begin
    if (frame_seen && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "reply", int'(reply), e);
      last_reply = e;
      frame_seen = 1'b0;
    end
  end

  task automatic check_counts(input string tag);
    for (int i = 0; i < 4; i++) begin
      check(tag, $sformatf("ch%0d count", i), int'(cnt[i*8 +: 8]), exp_cnt[i]);
    end
  endtask

  task automatic step(input bit tk, input logic [3:0] a, input logic [3:0] h,
                      input bit f, input logic [7:0] c, input string tag);
    @(negedge clk);
    tick = tk; act = a; hi = h; fv = f; cmd = c;
    if (f) begin
      int e;
      case (pend_kind)
        1: e = int'(h);
        2: e = exp_cnt[pend_ch];
        default: e = 0;
      endcase
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (c == 8'h79) pend_kind = 1;
      else if (c[7:4] == 4'h7 && c[3:0] < 4) begin pend_kind = 2; pend_ch = int'(c[1:0]); end
      else pend_kind = 0;
    end
    for (int i = 0; i < 4; i++) begin
      if (f && c[7:4] == 4'h3 && c[i]) exp_cnt[i] = 0;
      else if (tk && a[i] && h[i] && exp_cnt[i] < 255) exp_cnt[i]++;
    end
    @(posedge clk);
    #1;
    if (f) frame_seen = 1'b1;
    tick = 1'b0; fv = 1'b0;
    @(negedge clk);
    #1;
    check_counts(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_counts("R1");
    check("R1", "reply", int'(reply), 0);

    // R2 / R3: mixed qualification per channel
    repeat (5) step(1'b1, 4'b0111, 4'b1101, 1'b0, 8'h00, "R2");
    // R3: no tick while qualified
    repeat (3) step(1'b0, 4'b1111, 4'b1111, 1'b0, 8'h00, "R3");
    // R3: driver off, comparator on
    repeat (2) step(1'b1, 4'b0000, 4'b1111, 1'b0, 8'h00, "R3");

    // R4: drive channel 1 to saturation
    repeat (300) step(1'b1, 4'b0010, 4'b0010, 1'b0, 8'h00, "R4");
    check("R4", "ch1 saturated", int'(cnt[15:8]), 255);

    // R8: request readback of channel 1, answered on next frame
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 8'h71, "R9");
    // R6/R5: clear ch0 and ch1 while all channels qualified; reply takes pre-clear ch1
    step(1'b1, 4'b1111, 4'b1111, 1'b1, 8'h33, "R8");
    check("R6", "ch1 after clear+tick", int'(cnt[15:8]), 0);
    check("R5", "ch2 unmasked", int'(cnt[23:16]), exp_cnt[2]);
    // R9: reply holds with no frame
    step(1'b1, 4'b1111, 4'b1111, 1'b0, 8'h00, "R3");
    check("R9", "reply hold", int'(reply), last_reply);

    // R7: status request, answered with comparator vector at the next frame
    step(1'b0, 4'b0000, 4'b0110, 1'b1, 8'h79, "R9");
    step(1'b0, 4'b0000, 4'b1010, 1'b1, 8'h72, "R7");
    step(1'b0, 4'b0000, 4'b0101, 1'b1, 8'h79, "R8");
    step(1'b0, 4'b0000, 4'b0011, 1'b1, 8'h00, "R7");
    step(1'b0, 4'b0000, 4'b1111, 1'b1, 8'h00, "R9");
    // R5: clear with mask 0100 only
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 8'h34, "R5");
    // R8: out-of-range readback code carries no request
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 8'h74, "R9");
    step(1'b0, 4'b0000, 4'b0000, 1'b1, 8'h00, "R9");
    step(1'b0, 4'b0000, 4'b0000, 1'b0, 8'h00, "R9");
    check("R9", "reply hold end", int'(reply), last_reply);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule